// File: doc/BRIEF.md
# EPROM Signature Identifier Reader

This block reads the two identification bytes from a UV-erasable EPROM before a programmer starts writing it. A single `start_i` pulse begins a sequence. The block raises a request for the high-voltage level on the signature address line (bit 9) and drives every other address line low. It also holds the active-low chip and output enables asserted. It then reads the byte selected by address bit 0 low, which is the manufacturer code. Next it moves address bit 0 high and reads the device code.

Each read waits a parameterised number of clock cycles before the data bus is captured. The first read waits a settle time after the high-voltage request rises. The second read waits an access time after address bit 0 changes. When both bytes are captured, the block drops the high-voltage request and releases both enables. It then raises `done_o`, and `match_o` reports whether both bytes equal the expected codes.

The analogue switch that produces the high voltage is outside this block. The block only drives `hv_en_o`, and on `addr_o` the signature line stays at logic low.

Top module: `sig_id_reader`

## Requirements
- R1: While reset is asserted and after it is released, with no start, the outputs are `hv_en_o`=0, `ce_no`=1, `oe_no`=1, `addr_o`=0, `done_o`=0 and `match_o`=0.
- R2: Whenever `hv_en_o` is 1, `ce_no` and `oe_no` are 0 and every `addr_o` bit except bit 0 is 0.
- R3: On entry to signature mode `addr_o[0]` is 0. `data_i` is captured into `mfr_o` on the clock edge that ends the SETTLE_CYC-th cycle with `hv_en_o` high.
- R4: After the manufacturer capture, `addr_o[0]` goes to 1. `data_i` is captured into `dev_o` on the edge that ends the ACCESS_CYC-th cycle with `addr_o[0]` high.
- R5: `match_o` is 1 only when `mfr_o` equals EXP_MFR (default 0x04, only data bit 2 set) and `dev_o` equals EXP_DEV (default 0xE3, bits 7, 6, 5, 1 and 0 set). In every other case `match_o` is 0.
- R6: `hv_en_o` goes to 0, and `ce_no` and `oe_no` go to 1, one cycle before `done_o` rises. `hv_en_o` is never 1 while `done_o` is 1.
- R7: `done_o` and the captured results stay constant until the next `start_i`. A `start_i` that arrives during a sequence has no effect.
- R8: With `start_i` sampled high at clock edge k, `done_o` becomes 1 after edge k+SETTLE_CYC+ACCESS_CYC+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a signature read (accepted when idle or done) |
| data_i | input | 8 | EPROM data bus |
| addr_o | output | ADDR_W | EPROM address lines; bit 0 selects the identifier byte |
| hv_en_o | output | 1 | Request for high voltage on the signature address line |
| ce_no | output | 1 | Chip enable, active low |
| oe_no | output | 1 | Output enable, active low |
| mfr_o | output | 8 | Captured manufacturer byte |
| dev_o | output | 8 | Captured device byte |
| match_o | output | 1 | Both bytes equal the expected codes |
| done_o | output | 1 | Sequence complete, results valid |

## Verification
The bench builds the block with SETTLE_CYC=5 and ACCESS_CYC=3 and keeps the default expected codes 0x04 and 0xE3. The short waits keep each run brief. The bench's memory model returns a garbage byte until the settle or access window has fully elapsed, so a capture that is one cycle early shows up as a wrong byte. The exact latency S+A+2 can be counted directly. Keeping the default codes means the true identifier bytes, and single-bit or single-byte deviations from them, exercise the match logic.

// File: rtl/sig_id_pkg.sv
package sig_id_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DEV,
    ST_RELEASE,
    ST_DONE
  } sig_state_e;
endpackage

// File: rtl/sig_id_timer.sv
module sig_id_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sig_id_cmp.sv
module sig_id_cmp #(
  parameter logic [7:0] EXP_MFR = 8'h04,
  parameter logic [7:0] EXP_DEV = 8'hE3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       cap_mfr_i,
  input  logic       cap_dev_i,
  input  logic       judge_i,
  input  logic [7:0] data_i,
  output logic [7:0] mfr_o,
  output logic [7:0] dev_o,
  output logic       match_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mfr_o   <= '0;
      dev_o   <= '0;
      match_o <= 1'b0;
    end else if (clr_i) begin
      mfr_o   <= '0;
      dev_o   <= '0;
      match_o <= 1'b0;
    end else begin
      if (cap_mfr_i) mfr_o <= data_i;
      if (cap_dev_i) dev_o <= data_i;
      if (judge_i)   match_o <= (mfr_o == EXP_MFR) && (dev_o == EXP_DEV);
    end
  end
endmodule

// File: rtl/sig_id_fsm.sv
module sig_id_fsm
  import sig_id_pkg::*;
#(
  parameter int SETTLE_CYC = 5,
  parameter int ACCESS_CYC = 3,
  parameter int TW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          hv_en_o,
  output logic          rd_en_o,
  output logic          a0_o,
  output logic          cap_mfr_o,
  output logic          cap_dev_o,
  output logic          judge_o,
  output logic          clr_o,
  output logic          done_o
);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] ACCESS_LD = TW'(ACCESS_CYC - 1);

  sig_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = SETTLE_LD;
    cap_mfr_o  = 1'b0;
    cap_dev_o  = 1'b0;
    judge_o    = 1'b0;
    clr_o      = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        state_d    = ST_SETTLE;
        tmr_load_o = 1'b1;
        clr_o      = 1'b1;
      end
      ST_SETTLE: if (tmr_zero_i) begin
        state_d    = ST_DEV;
        cap_mfr_o  = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = ACCESS_LD;
      end
      ST_DEV: if (tmr_zero_i) begin
        state_d   = ST_RELEASE;
        cap_dev_o = 1'b1;
      end
      ST_RELEASE: begin
        state_d = ST_DONE;
        judge_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // signature pins are active only in the two read phases
  assign hv_en_o = (state_q == ST_SETTLE) || (state_q == ST_DEV);
  assign rd_en_o = hv_en_o;
  assign a0_o    = (state_q == ST_DEV);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/sig_id_reader.sv
module sig_id_reader #(
  parameter int         ADDR_W     = 16,
  parameter int         SETTLE_CYC = 5,
  parameter int         ACCESS_CYC = 3,
  parameter logic [7:0] EXP_MFR    = 8'h04,
  parameter logic [7:0] EXP_DEV    = 8'hE3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              hv_en_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic [7:0]        mfr_o,
  output logic [7:0]        dev_o,
  output logic              match_o,
  output logic              done_o
);
  localparam int MAX_CYC = (SETTLE_CYC > ACCESS_CYC) ? SETTLE_CYC : ACCESS_CYC;
  localparam int TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic          tmr_load, tmr_zero, rd_en, a0;
  logic          cap_mfr, cap_dev, judge, clr;
  logic [TW-1:0] tmr_val;

  sig_id_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sig_id_fsm #(
    .SETTLE_CYC (SETTLE_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .TW         (TW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .hv_en_o    (hv_en_o),
    .rd_en_o    (rd_en),
    .a0_o       (a0),
    .cap_mfr_o  (cap_mfr),
    .cap_dev_o  (cap_dev),
    .judge_o    (judge),
    .clr_o      (clr),
    .done_o     (done_o)
  );

  sig_id_cmp #(.EXP_MFR(EXP_MFR), .EXP_DEV(EXP_DEV)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .cap_mfr_i (cap_mfr),
    .cap_dev_i (cap_dev),
    .judge_i   (judge),
    .data_i    (data_i),
    .mfr_o     (mfr_o),
    .dev_o     (dev_o),
    .match_o   (match_o)
  );

  // bit 9 stays logic low: its high level comes from the external switch
  assign addr_o = {{(ADDR_W-1){1'b0}}, a0};
  assign ce_no  = ~rd_en;
  assign oe_no  = ~rd_en;
endmodule

// File: rtl/sig_id_reader_chk.sv
module sig_id_reader_chk #(
  parameter int ADDR_W     = 16,
  parameter int SETTLE_CYC = 5,
  parameter int ACCESS_CYC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              hv_en_o,
  input logic              ce_no,
  input logic              oe_no,
  input logic [7:0]        mfr_o,
  input logic [7:0]        dev_o,
  input logic              match_o,
  input logic              done_o
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (!hv_en_o)                       lo_cnt <= '0;
      else if (!addr_o[0] && lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      if (!hv_en_o)                       hi_cnt <= '0;
      else if (addr_o[0] && hi_cnt != '1)  hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_PINS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> (!ce_no && !oe_no && addr_o[ADDR_W-1:1] == '0)); // R2
  AST_A0_LOW_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hv_en_o) |-> !addr_o[0]); // R3
  AST_SETTLE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_en_o && $rose(addr_o[0])) |-> (lo_cnt >= 16'(SETTLE_CYC))); // R3
  AST_ACCESS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hv_en_o) |-> (hi_cnt >= 16'(ACCESS_CYC))); // R4
  AST_MATCH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o); // R5
  AST_HV_OFF_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!hv_en_o && ce_no && oe_no)); // R6
  AST_RELEASE_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!hv_en_o && ce_no)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(mfr_o) && $stable(dev_o) && $stable(match_o))); // R7
endmodule

bind sig_id_reader sig_id_reader_chk #(
  .ADDR_W     (ADDR_W),
  .SETTLE_CYC (SETTLE_CYC),
  .ACCESS_CYC (ACCESS_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .addr_o  (addr_o),
  .hv_en_o (hv_en_o),
  .ce_no   (ce_no),
  .oe_no   (oe_no),
  .mfr_o   (mfr_o),
  .dev_o   (dev_o),
  .match_o (match_o),
  .done_o  (done_o)
);

// File: tb/sig_id_reader_tb.sv
module sig_id_reader_tb;
  localparam int ADDR_W = 16;
  localparam int S      = 5;
  localparam int A      = 3;
  localparam logic [7:0] JUNK = 8'h5A;

  // {mfr returned, dev returned, expected match}
  localparam logic [16:0] VEC [6] = '{
    {8'h04, 8'hE3, 1'b1},
    {8'h04, 8'hE2, 1'b0},
    {8'h05, 8'hE3, 1'b0},
    {8'hFF, 8'hFF, 1'b0},
    {8'hE3, 8'h04, 1'b0},
    {8'h00, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] data;
  logic [ADDR_W-1:0] addr;
  logic hv_en, ce_n, oe_n, match, done;
  logic [7:0] mfr, dev;
  logic [7:0] rom_mfr = 8'h04, rom_dev = 8'hE3;
  int hv_age, dev_age;
  int checks = 0, failures = 0, pin_viol = 0, hv_done_viol = 0;

  always #10 clk = ~clk;

  sig_id_reader #(.ADDR_W(ADDR_W), .SETTLE_CYC(S), .ACCESS_CYC(A)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
    .addr_o(addr), .hv_en_o(hv_en), .ce_no(ce_n), .oe_no(oe_n),
    .mfr_o(mfr), .dev_o(dev), .match_o(match), .done_o(done)
  );

  // memory model: valid bytes only after the full settle / access window
  always @(posedge clk) begin
    hv_age  <= hv_en ? hv_age + 1 : 0;
    dev_age <= (hv_en && addr[0]) ? dev_age + 1 : 0;
  end

  always_comb begin
    data = 8'hFF;
    if (hv_en && !ce_n && !oe_n && addr[13:1] == '0) begin
      if (!addr[0]) data = (hv_age >= S-1) ? rom_mfr : JUNK;
      else          data = (dev_age >= A-1) ? rom_dev : JUNK;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (hv_en && (ce_n || oe_n || addr[ADDR_W-1:1] != '0)) pin_viol++;
    if (hv_en && done) hv_done_viol++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic mid_start, output int lat);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
      if (mid_start && lat == 3) start = 1'b1;
      else start = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1 hv_en", hv_en, 0);
    check("R1 ce_n/oe_n", {ce_n, oe_n}, 2'b11);
    check("R1 addr", addr, 0);
    check("R1 done/match", {done, match}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", {hv_en, done, ce_n}, 3'b001);

    for (int i = 0; i < 6; i++) begin
      rom_mfr = VEC[i][16:9];
      rom_dev = VEC[i][8:1];
      run(1'b0, lat);
      check("R3 mfr capture", mfr, VEC[i][16:9]);
      check("R4 dev capture", dev, VEC[i][8:1]);
      check("R5 match", match, VEC[i][0]);
      check("R8 latency", lat, S + A + 2);
    end

    // R7: results hold while done, no start
    repeat (10) @(negedge clk);
    check("R7 done held", done, 1);
    check("R7 dev held", dev, 8'h00);

    // R7: start during a sequence ignored
    rom_mfr = 8'h04; rom_dev = 8'hE3;
    run(1'b1, lat);
    check("R7 mid start latency", lat, S + A + 2);
    check("R7 mid start match", match, 1);

    // R6 / R2 from the pin monitor
    check("R2 pin levels", pin_viol, 0);
    check("R6 hv off at done", hv_done_viol, 0);
    check("R6 enables released", {hv_en, ce_n, oe_n}, 3'b011);

    // R1: reset during a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid run", {hv_en, done, match, ce_n}, 4'b0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule